// File: doc/BRIEF.md
# Single-Precision Floating-Point Adder/Subtractor

This block adds or subtracts two 32-bit binary floating-point words. Each word holds a sign bit in bit 31, an 8-bit exponent in bits 30:23 with a bias of 127, and a 23-bit fraction in bits 22:0. The unit splits both operands into fields and restores the implicit leading one of normal numbers. For subtraction it inverts the sign of B. It then orders the operands by magnitude and shifts the smaller significand right until the two exponents match.

During that shift only a guard bit and a round bit are kept below the result LSB. Every bit pushed past them is ORed into a single sticky bit. After the significand add or subtract, the sum is renormalized: one right shift on a carry out, or a left shift by the leading-zero count. The left shift is limited so that results which are too small come out as denormals. The result is then rounded to nearest, with ties going to even. Infinity, NaN, signed zero and denormal encodings are all handled.

The result and three flags (invalid, overflow, inexact) are registered once, so they appear one clock after the operands are applied. A parameter can remove this register.

Top module: `fpadd_core`

## Requirements
- R1: With sub_op low, the result is the correctly rounded sum of two finite normal operands (sign in bit 31, 8-bit exponent with bias 127 in bits 30:23, fraction in bits 22:0, implicit leading one).
- R2: With sub_op high, the result equals A plus B with the sign bit of B inverted.
- R3: Every result with a nonzero exponent field has a leading one. A carry out of the significand sum shifts right once and raises the exponent by one. Cancellation shifts left by the leading-zero count and lowers the exponent by the same amount.
- R4: Rounding is to nearest, using guard, round and sticky bits. An exact halfway case rounds to the result whose LSB is 0.
- R5: When the exponent difference is more than 26, the smaller operand affects only the sticky bit. The result is then the larger operand after rounding, with inexact set.
- R6: An exponent field of 0 with a nonzero fraction is a denormal, with no hidden bit and weight 2^-126. Sums of denormals are exact. Results below the normal range are produced as denormals, and denormal sums that reach 2^-126 become normal.
- R7: An effective subtraction of equal magnitudes gives +0 (0x00000000). Adding two zeros of the same sign gives a zero of that sign.
- R8: If the rounded exponent reaches 255, either from the significand carry or from rounding, the result is infinity of the result sign, and overflow and inexact are set.
- R9: Any NaN operand (exponent 255, fraction nonzero), or infinity minus infinity, gives 0x7FC00000 with invalid set and the other two flags clear.
- R10: An infinite operand combined with a finite operand, or with an infinity of the same effective sign, gives that infinity with all flags clear.
- R11: The inexact flag is set exactly when any of guard, round or sticky is nonzero after renormalization.
- R12: Result and flags are registered. They are zero during reset, and they change only on the rising clock edge that follows the change of the operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_a | input | 32 | Operand A |
| op_b | input | 32 | Operand B |
| sub_op | input | 1 | 1 selects A minus B, 0 selects A plus B |
| result | output | 32 | Packed rounded result |
| flag_invalid | output | 1 | NaN operand, or infinity minus infinity |
| flag_overflow | output | 1 | Rounded result exceeded the largest finite value |
| flag_inexact | output | 1 | Result differs from the exact value |

## Verification
The hardest cases to reach from the ports are those where the outcome depends on one bit far below the result LSB. Examples are a halfway case decided only by a sticky bit, and a subtraction in which the sticky bit borrows and then forces a left shift followed by a round-up carry. The stimulus builds these directly. The second operand's exponent is set exactly 24 or 30 below the first, and its lowest fraction bit is either set or clear, so guard, round and sticky take chosen values. Rounding-induced overflow is reached by adding half an ULP of the largest finite value to that value.

// File: rtl/fpadd_pkg.sv
package fpadd_pkg;

   typedef enum logic [1:0] {
      CLS_ZERO   = 2'd0,
      CLS_FINITE = 2'd1,
      CLS_INF    = 2'd2,
      CLS_NAN    = 2'd3
   } fp_class_e;

endpackage

// File: rtl/fpadd_unpack.sv
module fpadd_unpack
   import fpadd_pkg::*;
#(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
   input  logic [WORD_W-1:0] word,
   output logic              sign,
   output logic [EXP_W-1:0]  exp_eff,
   output logic [FRAC_W:0]   sig,
   output fp_class_e         cls
);

   logic [EXP_W-1:0]  exp_fld;
   logic [FRAC_W-1:0] frac_fld;
   logic              exp_zero, exp_ones, frac_zero;

   assign sign      = word[WORD_W-1];
   assign exp_fld   = word[WORD_W-2 -: EXP_W];
   assign frac_fld  = word[FRAC_W-1:0];
   assign exp_zero  = (exp_fld == '0);
   assign exp_ones  = (exp_fld == '1);
   assign frac_zero = (frac_fld == '0);

   // denormals share the weight of exponent field 1, without the hidden one
   assign exp_eff = exp_zero ? EXP_W'(1) : exp_fld;
   assign sig     = {~exp_zero, frac_fld};

   always_comb begin
      if (exp_ones)
         cls = frac_zero ? CLS_INF : CLS_NAN;
      else if (exp_zero && frac_zero)
         cls = CLS_ZERO;
      else
         cls = CLS_FINITE;
   end

endmodule

// File: rtl/fpadd_align.sv
module fpadd_align #(
   parameter int EXP_W = 8,
   parameter int SIG_W = 24,
   localparam int SH_W  = SIG_W + 2,
   localparam int EXT_W = SIG_W + 3,
   localparam int DD_W  = $clog2(SH_W + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             a_sign,
   input  logic [EXP_W-1:0] a_exp,
   input  logic [SIG_W-1:0] a_sig,
   input  logic             b_sign,
   input  logic [EXP_W-1:0] b_exp,
   input  logic [SIG_W-1:0] b_sig,
   output logic             big_sign,
   output logic [EXP_W-1:0] big_exp,
   output logic [EXT_W-1:0] big_ext,
   output logic [EXT_W-1:0] small_ext,
   output logic             eff_sub
);

   logic             a_ge_b;
   logic [EXP_W-1:0] small_exp, diff;
   logic [SIG_W-1:0] big_sig, small_sig;
   logic [SH_W-1:0]  wide, shifted;
   logic [DD_W-1:0]  dd;
   logic             lost;

   assign a_ge_b    = {a_exp, a_sig} >= {b_exp, b_sig};
   assign big_sign  = a_ge_b ? a_sign : b_sign;
   assign big_exp   = a_ge_b ? a_exp  : b_exp;
   assign big_sig   = a_ge_b ? a_sig  : b_sig;
   assign small_exp = a_ge_b ? b_exp  : a_exp;
   assign small_sig = a_ge_b ? b_sig  : a_sig;
   assign eff_sub   = a_sign ^ b_sign;

   assign diff = big_exp - small_exp;
   // beyond SH_W every bit of the small significand lands in the sticky bit
   assign dd   = (diff > EXP_W'(SH_W)) ? DD_W'(SH_W) : DD_W'(diff);

   assign wide      = {small_sig, 2'b00};
   assign shifted   = wide >> dd;
   assign lost      = |(wide << (DD_W'(SH_W) - dd));
   assign small_ext = {shifted, lost};
   assign big_ext   = {big_sig, 3'b000};

   // R5: the aligned smaller operand never exceeds the larger one
   assert_align_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      big_ext >= small_ext);

   // R5: a far operand reduces to a lone sticky bit
   assert_far_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (diff > EXP_W'(SH_W)) |-> (small_ext[EXT_W-1:1] == '0));

endmodule

// File: rtl/fpadd_normround.sv
module fpadd_normround #(
   parameter int EXP_W  = 8,
   parameter int FRAC_W = 23,
   localparam int SIG_W  = FRAC_W + 1,
   localparam int EXT_W  = SIG_W + 3,
   localparam int SUM_W  = EXT_W + 1,
   localparam int EW2    = EXP_W + 2,
   localparam int LZ_W   = $clog2(EXT_W + 1),
   localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [SUM_W-1:0]  s,
   input  logic [EXP_W-1:0]  exp_in,
   input  logic              sign,
   input  logic              zero_sign,
   output logic [WORD_W-1:0] word,
   output logic              ovf,
   output logic              inexact
);

   localparam logic [EW2-1:0] EXP_MAX = {2'b00, {EXP_W{1'b1}}};

   logic [EW2-1:0]   e_wide, e_n, lim, sh, fld;
   logic [LZ_W-1:0]  lz;
   logic [EXT_W-1:0] m;
   logic [SIG_W:0]   rnd;
   logic             g, r, st, up;

   assign e_wide = {2'b00, exp_in};

   always_comb begin
      lz = LZ_W'(EXT_W);
      for (int i = 0; i < EXT_W; i++)
         if (s[i]) lz = LZ_W'(EXT_W - 1 - i);
   end

   always_comb begin
      lim = e_wide - EW2'(1);
      sh  = (EW2'(lz) < lim) ? EW2'(lz) : lim;
      if (s[SUM_W-1]) begin
         m   = {s[SUM_W-1:2], s[1] | s[0]};
         e_n = e_wide + EW2'(1);
      end else begin
         m   = s[EXT_W-1:0] << sh;
         e_n = e_wide - sh;
      end
   end

   assign g   = m[2];
   assign r   = m[1];
   assign st  = m[0];
   assign up  = g & (r | st | m[3]);
   assign rnd = {1'b0, m[EXT_W-1:3]} + {{SIG_W{1'b0}}, up};

   always_comb begin
      if (rnd[SIG_W])
         fld = e_n + EW2'(1);
      else if (rnd[SIG_W-1])
         fld = e_n;
      else
         fld = '0;
   end

   always_comb begin
      ovf     = 1'b0;
      inexact = g | r | st;
      if (s == '0) begin
         word    = {zero_sign, {(WORD_W-1){1'b0}}};
      end else if (fld >= EXP_MAX) begin
         ovf     = 1'b1;
         inexact = 1'b1;
         word    = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else begin
         word    = {sign, fld[EXP_W-1:0],
                    rnd[SIG_W] ? {FRAC_W{1'b0}} : rnd[FRAC_W-1:0]};
      end
   end

   // R3: above the denormal floor the shifter leaves a leading one
   assert_norm_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((s != '0) && (e_n > EW2'(1))) |-> m[EXT_W-1]);

   // R4: an exact halfway case always lands on an even significand
   assert_tie_even_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (g && !r && !st) |-> !rnd[0]);

endmodule

// File: rtl/fpadd_core.sv
module fpadd_core
   import fpadd_pkg::*;
#(
   parameter int EXP_W   = 8,
   parameter int FRAC_W  = 23,
   parameter bit OUT_REG = 1'b1,
   localparam int WORD_W = 1 + EXP_W + FRAC_W,
   localparam int SIG_W  = FRAC_W + 1,
   localparam int EXT_W  = SIG_W + 3,
   localparam int SUM_W  = EXT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [WORD_W-1:0] op_a,
   input  logic [WORD_W-1:0] op_b,
   input  logic              sub_op,
   output logic [WORD_W-1:0] result,
   output logic              flag_invalid,
   output logic              flag_overflow,
   output logic              flag_inexact
);

   if (EXP_W < 3 || FRAC_W < 3) begin : g_bad_fmt
      $error("fpadd_core: exponent and fraction need at least 3 bits");
   end
   if ((SIG_W + 2) >= (2 ** EXP_W)) begin : g_bad_range
      $error("fpadd_core: exponent range too small for the shift clamp");
   end

   localparam logic [WORD_W-1:0] QNAN =
      {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

   logic             a_sign, b_sign, big_sign, eff_sub;
   logic [EXP_W-1:0] a_exp, b_exp, big_exp;
   logic [SIG_W-1:0] a_sig, b_sig;
   fp_class_e        a_cls, b_cls;
   logic [EXT_W-1:0] big_ext, small_ext;
   logic [SUM_W-1:0] sum_w;
   logic [WORD_W-1:0] fin_word, nxt_word;
   logic             fin_ovf, fin_inx, nxt_inv, nxt_ovf, nxt_inx;

   fpadd_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_a (
      .word(op_a), .sign(a_sign), .exp_eff(a_exp), .sig(a_sig), .cls(a_cls));

   fpadd_unpack #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_unp_b (
      .word({op_b[WORD_W-1] ^ sub_op, op_b[WORD_W-2:0]}),
      .sign(b_sign), .exp_eff(b_exp), .sig(b_sig), .cls(b_cls));

   fpadd_align #(.EXP_W(EXP_W), .SIG_W(SIG_W)) u_align (
      .clk(clk), .rst_n(rst_n),
      .a_sign(a_sign), .a_exp(a_exp), .a_sig(a_sig),
      .b_sign(b_sign), .b_exp(b_exp), .b_sig(b_sig),
      .big_sign(big_sign), .big_exp(big_exp), .big_ext(big_ext),
      .small_ext(small_ext), .eff_sub(eff_sub));

   assign sum_w = eff_sub ? ({1'b0, big_ext} - {1'b0, small_ext})
                          : ({1'b0, big_ext} + {1'b0, small_ext});

   fpadd_normround #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_nr (
      .clk(clk), .rst_n(rst_n),
      .s(sum_w), .exp_in(big_exp), .sign(big_sign),
      .zero_sign(eff_sub ? 1'b0 : big_sign),
      .word(fin_word), .ovf(fin_ovf), .inexact(fin_inx));

   always_comb begin
      nxt_inv  = 1'b0;
      nxt_ovf  = 1'b0;
      nxt_inx  = 1'b0;
      nxt_word = fin_word;
      if (a_cls == CLS_NAN || b_cls == CLS_NAN ||
          (a_cls == CLS_INF && b_cls == CLS_INF && eff_sub)) begin
         nxt_inv  = 1'b1;
         nxt_word = QNAN;
      end else if (a_cls == CLS_INF) begin
         nxt_word = {a_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else if (b_cls == CLS_INF) begin
         nxt_word = {b_sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
      end else begin
         nxt_ovf  = fin_ovf;
         nxt_inx  = fin_inx;
      end
   end

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            result        <= '0;
            flag_invalid  <= 1'b0;
            flag_overflow <= 1'b0;
            flag_inexact  <= 1'b0;
         end else begin
            result        <= nxt_word;
            flag_invalid  <= nxt_inv;
            flag_overflow <= nxt_ovf;
            flag_inexact  <= nxt_inx;
         end
      end
   end else begin : g_out_comb
      assign result        = nxt_word;
      assign flag_invalid  = nxt_inv;
      assign flag_overflow = nxt_ovf;
      assign flag_inexact  = nxt_inx;
   end

   // R9: an invalid result is always the quiet NaN with no other flag
   assert_invalid_qnan_R9: assert property (@(posedge clk) disable iff (!rst_n)
      flag_invalid |-> (result == QNAN && !flag_overflow && !flag_inexact));

   // R8: overflow yields an infinity and is always inexact
   assert_overflow_inf_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flag_overflow |-> (result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}}
                         && flag_inexact));

   // R10: an infinite result without overflow raises no flag
   assert_inf_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (result[WORD_W-2:0] == {{EXP_W{1'b1}}, {FRAC_W{1'b0}}} && !flag_overflow)
      |-> (!flag_invalid && !flag_inexact));

endmodule

// File: tb/fpadd_core_test.sv
module fpadd_core_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] op_a = '0, op_b = '0;
   logic        sub_op = 1'b0;
   logic [31:0] result;
   logic        flag_invalid, flag_overflow, flag_inexact;
   int          n_checks = 0;
   int          n_fail = 0;
   bit          done = 1'b0;

   always #5 clk = ~clk;

   fpadd_core uut (
      .clk(clk), .rst_n(rst_n), .op_a(op_a), .op_b(op_b), .sub_op(sub_op),
      .result(result), .flag_invalid(flag_invalid),
      .flag_overflow(flag_overflow), .flag_inexact(flag_inexact));

   task automatic check(input string tag, input logic [31:0] exp_r,
                        input logic e_inv, input logic e_ovf, input logic e_inx);
      n_checks++;
      if (result !== exp_r || flag_invalid !== e_inv ||
          flag_overflow !== e_ovf || flag_inexact !== e_inx) begin
         n_fail++;
         $display("FAIL %s: got %h inv=%b ovf=%b inx=%b, expected %h inv=%b ovf=%b inx=%b",
                  tag, result, flag_invalid, flag_overflow, flag_inexact,
                  exp_r, e_inv, e_ovf, e_inx);
      end
   endtask

   // drive at a falling edge, result is registered at the next rising edge
   task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic s);
      @(negedge clk);
      op_a = a; op_b = b; sub_op = s;
      @(negedge clk);
   endtask

   task automatic op(input string tag, input logic [31:0] a, input logic [31:0] b,
                     input logic s, input logic [31:0] exp_r,
                     input logic e_inv, input logic e_ovf, input logic e_inx);
      apply(a, b, s);
      check(tag, exp_r, e_inv, e_ovf, e_inx);
   endtask

   task automatic t_reset();
      check("R12 reset", 32'h0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic t_basic_add();
      op("R1 1+2", 32'h3F800000, 32'h40000000, 1'b0, 32'h40400000, 0, 0, 0);
      op("R11 exact no inexact", 32'h40A00000, 32'hC0400000, 1'b0, 32'h40000000, 0, 0, 0);
   endtask

   task automatic t_subtract();
      op("R2 3-1", 32'h40400000, 32'h3F800000, 1'b1, 32'h40000000, 0, 0, 0);
      op("R2 1-(-1)", 32'h3F800000, 32'hBF800000, 1'b1, 32'h40000000, 0, 0, 0);
   endtask

   task automatic t_renorm();
      op("R3 carry 1.5+2.5", 32'h3FC00000, 32'h40200000, 1'b0, 32'h40800000, 0, 0, 0);
      op("R3 cancel 1-0.75", 32'h3F800000, 32'h3F400000, 1'b1, 32'h3E800000, 0, 0, 0);
   endtask

   task automatic t_round();
      op("R4 tie to even down", 32'h3F800000, 32'h33800000, 1'b0, 32'h3F800000, 0, 0, 1);
      op("R4 tie to even up", 32'h3F800001, 32'h33800000, 1'b0, 32'h3F800002, 0, 0, 1);
      op("R4 above half G R", 32'h3F800000, 32'h33C00000, 1'b0, 32'h3F800001, 0, 0, 1);
      op("R4 sticky breaks tie", 32'h3F800000, 32'h33800001, 1'b0, 32'h3F800001, 0, 0, 1);
   endtask

   task automatic t_far();
      op("R5 far add", 32'h3F800000, 32'h30800000, 1'b0, 32'h3F800000, 0, 0, 1);
      op("R5 far sub", 32'h3F800000, 32'h30800000, 1'b1, 32'h3F800000, 0, 0, 1);
      op("R5 far swapped", 32'h30800000, 32'h3F800000, 1'b0, 32'h3F800000, 0, 0, 1);
   endtask

   task automatic t_denormal();
      op("R6 denorm sum", 32'h00000001, 32'h00000001, 1'b0, 32'h00000002, 0, 0, 0);
      op("R6 denorm to normal", 32'h00400000, 32'h00400000, 1'b0, 32'h00800000, 0, 0, 0);
      op("R6 gradual underflow", 32'h00800001, 32'h00800000, 1'b1, 32'h00000001, 0, 0, 0);
   endtask

   task automatic t_zero();
      op("R7 equal cancel", 32'hC0400000, 32'hC0400000, 1'b1, 32'h00000000, 0, 0, 0);
      op("R7 -0 + -0", 32'h80000000, 32'h80000000, 1'b0, 32'h80000000, 0, 0, 0);
      op("R7 +0 + -0", 32'h00000000, 32'h80000000, 1'b0, 32'h00000000, 0, 0, 0);
   endtask

   task automatic t_overflow();
      op("R8 carry overflow", 32'h7F7FFFFF, 32'h7F7FFFFF, 1'b0, 32'h7F800000, 0, 1, 1);
      op("R8 round overflow", 32'hFF7FFFFF, 32'hF3000000, 1'b0, 32'hFF800000, 0, 1, 1);
   endtask

   task automatic t_specials();
      op("R9 quiet NaN in", 32'h7FC00000, 32'h3F800000, 1'b0, 32'h7FC00000, 1, 0, 0);
      op("R9 signaling NaN in", 32'h00000000, 32'hFF800001, 1'b0, 32'h7FC00000, 1, 0, 0);
      op("R9 inf minus inf", 32'h7F800000, 32'h7F800000, 1'b1, 32'h7FC00000, 1, 0, 0);
      op("R10 -inf + 1", 32'hFF800000, 32'h3F800000, 1'b0, 32'hFF800000, 0, 0, 0);
      op("R10 1 - -inf", 32'h3F800000, 32'hFF800000, 1'b1, 32'h7F800000, 0, 0, 0);
      op("R10 inf + inf", 32'h7F800000, 32'h7F800000, 1'b0, 32'h7F800000, 0, 0, 0);
   endtask

   task automatic t_latency();
      apply(32'h3F800000, 32'h40000000, 1'b0);
      @(negedge clk);
      op_a = 32'h40400000; op_b = 32'h3F800000; sub_op = 1'b1;
      #2;
      check("R12 holds before edge", 32'h40400000, 0, 0, 0);
      @(negedge clk);
      check("R12 updates after edge", 32'h40000000, 0, 0, 0);
   endtask

   initial begin
      #1;
      t_reset();
      #20;
      @(negedge clk);
      rst_n = 1'b1;
      t_basic_add();
      t_subtract();
      t_renorm();
      t_round();
      t_far();
      t_denormal();
      t_zero();
      t_overflow();
      t_specials();
      t_latency();
      done = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
         $finish;
      end
   end

endmodule